// File: doc/BRIEF.md
# Four-Entry TLB Replacement Age Tracker

This block keeps the relative age of the four ways of a small fully associative instruction translation buffer. Age is held as six pairwise-order bits, one bit for each pair of ways, named L5 down to L0 (L5 is the most significant bit of the vector). Every time the lookup logic reports that a way was used, the block rewrites the vector to mark that way as the newest. This happens on a direct hit and also after a refill.

From the current vector the block decodes which way to evict on the next refill. It does this with fixed mask and value patterns checked in a set priority. Software can overwrite the whole vector at once. When the vector matches no eviction pattern, the block raises an error flag and names way 0 as the victim. The translation storage and the tag match logic live outside this block.

The block has no operating modes and no states beyond the vector register. The register holds its value until it sees one of two events: a write, which loads the vector, or a use strobe, which updates it.

Top module: `lru4_tracker`

## Requirements
- R1: After reset the vector is 000000, the victim output is 3 and the error flag is 0.
- R2: A use of way 0 (use_idx = 0) clears L5, L4 and L3 and keeps L2..L0.
- R3: A use of way 1 sets L5, clears L2 and L1, and keeps L4, L3 and L0.
- R4: A use of way 2 sets L4 and L2, clears L0, and keeps L5, L3 and L1.
- R5: A use of way 3 sets L3, L1 and L0 and keeps L5, L4 and L2.
- R6: The victim is decoded in priority order: way 0 when L5=L4=L3=1; else way 1 when L5=0, L2=0 and L1=1; else way 2 when L4=0, L2=0 and L0=1; else way 3 when L3=L1=L0=0.
- R7: When no pattern of R6 matches, the error flag is 1 and the victim is 0. In every other case the error flag is 0.
- R8: A software write loads all six bits in one cycle. A write takes precedence over a use strobe in the same cycle, and that use has no effect.
- R9: With neither a use nor a write, the vector keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_valid | input | 1 | A way was hit or refilled in this cycle |
| use_idx | input | 2 | Index of the way used |
| wr_en | input | 1 | Software write of the vector |
| wr_vec | input | 6 | Value written, L5 in bit 5 |
| victim_idx | output | 2 | Way to replace on the next refill |
| age_vec | output | 6 | Current pairwise-order vector |
| bad_state | output | 1 | Vector matches no victim pattern |

## Verification
A use or a write changes age_vec at the first rising edge that samples it. victim_idx and bad_state are decoded combinationally from the register, so they follow in the same cycle, with no further delay.

The bench drives inputs on falling edges. It compares all three outputs at the next falling edge, after exactly one rising edge. This puts every sample half a period away from the edge where results change.

// File: rtl/lru4_pkg.sv
package lru4_pkg;
    localparam int WAYS  = 4;
    localparam int IDX_W = $clog2(WAYS);
    localparam int VEC_W = WAYS * (WAYS - 1) / 2;

    typedef logic [VEC_W-1:0] age_t;
    typedef logic [IDX_W-1:0] way_t;

    // Per-way clear and set masks, applied as (vec & keep) | set
    function automatic age_t keep_mask(way_t w);
        case (w)
            2'd0:    return 6'b000111;
            2'd1:    return 6'b111001;
            2'd2:    return 6'b111110;
            default: return 6'b111111;
        endcase
    endfunction

    function automatic age_t set_mask(way_t w);
        case (w)
            2'd0:    return 6'b000000;
            2'd1:    return 6'b100000;
            2'd2:    return 6'b010100;
            default: return 6'b001011;
        endcase
    endfunction
endpackage

// File: rtl/lru4_update.sv
module lru4_update
    import lru4_pkg::*;
(
    input  age_t cur_vec,
    input  logic use_valid,
    input  way_t use_idx,
    input  logic wr_en,
    input  age_t wr_vec,
    output age_t nxt_vec
);
    age_t touched;

    always_comb begin
        touched = (cur_vec & keep_mask(use_idx)) | set_mask(use_idx);
        if (wr_en)
            nxt_vec = wr_vec;
        else if (use_valid)
            nxt_vec = touched;
        else
            nxt_vec = cur_vec;
    end
endmodule

// File: rtl/lru4_victim.sv
module lru4_victim
    import lru4_pkg::*;
(
    input  age_t vec,
    output way_t victim,
    output logic no_match
);
    logic [WAYS-1:0] hit;

    always_comb begin
        hit[0] = vec[5] & vec[4] & vec[3];
        hit[1] = ~vec[5] & ~vec[2] & vec[1];
        hit[2] = ~vec[4] & ~vec[2] & vec[0];
        hit[3] = ~vec[3] & ~vec[1] & ~vec[0];
    end

    always_comb begin
        victim   = '0;
        no_match = 1'b0;
        unique casez (hit)
            4'b???1: victim = 2'd0;
            4'b??10: victim = 2'd1;
            4'b?100: victim = 2'd2;
            4'b1000: victim = 2'd3;
            4'b0000: no_match = 1'b1;
        endcase
    end
endmodule

// File: rtl/lru4_tracker.sv
module lru4_tracker
    import lru4_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       use_valid,
    input  logic [1:0] use_idx,
    input  logic       wr_en,
    input  logic [5:0] wr_vec,
    output logic [1:0] victim_idx,
    output logic [5:0] age_vec,
    output logic       bad_state
);
    age_t vec_q;
    age_t vec_d;

    lru4_update u_update (
        .cur_vec   (vec_q),
        .use_valid (use_valid),
        .use_idx   (use_idx),
        .wr_en     (wr_en),
        .wr_vec    (wr_vec),
        .nxt_vec   (vec_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_q <= '0;
        else
            vec_q <= vec_d;
    end

    lru4_victim u_victim (
        .vec      (vec_q),
        .victim   (victim_idx),
        .no_match (bad_state)
    );

    assign age_vec = vec_q;

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !use_valid) |=> $stable(age_vec));

    p_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> age_vec == $past(wr_vec));

    p_use0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (use_valid && !wr_en && use_idx == 2'd0) |=>
        (age_vec[5:3] == 3'b000 && age_vec[2:0] == $past(age_vec[2:0])));

    p_use3_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (use_valid && !wr_en && use_idx == 2'd3) |=>
        (age_vec[3] && age_vec[1] && age_vec[0]));

    p_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bad_state |-> victim_idx == 2'd0);

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (age_vec == '0 && victim_idx == 2'd3 && !bad_state));
endmodule

// File: tb/lru4_tracker_tb.sv
module lru4_tracker_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       use_valid;
    logic [1:0] use_idx;
    logic       wr_en;
    logic [5:0] wr_vec;
    logic [1:0] victim_idx;
    logic [5:0] age_vec;
    logic       bad_state;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lru4_tracker u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .use_valid  (use_valid),
        .use_idx    (use_idx),
        .wr_en      (wr_en),
        .wr_vec     (wr_vec),
        .victim_idx (victim_idx),
        .age_vec    (age_vec),
        .bad_state  (bad_state)
    );

    // {use index, expected vector, expected victim, expected error}
    localparam int NV = 10;
    localparam logic [10:0] VECS [NV] = '{
        {2'd0, 6'b000000, 2'd3, 1'b0},  // R2 from reset
        {2'd3, 6'b001011, 2'd1, 1'b0},  // R5, R6 way 1
        {2'd1, 6'b101001, 2'd2, 1'b0},  // R3, R6 way 2
        {2'd2, 6'b111100, 2'd0, 1'b0},  // R4, R6 way 0
        {2'd0, 6'b000100, 2'd3, 1'b0},  // R2, R6 way 3
        {2'd3, 6'b001111, 2'd0, 1'b1},  // R5, R7 no match
        {2'd1, 6'b101001, 2'd2, 1'b0},  // R3
        {2'd2, 6'b111100, 2'd0, 1'b0},  // R4
        {2'd1, 6'b111000, 2'd0, 1'b0},  // R3
        {2'd3, 6'b111011, 2'd0, 1'b0}   // R5
    };

    task automatic check(string req, logic [5:0] ev, logic [1:0] ew, logic ee);
        n_run++;
        if (age_vec !== ev || victim_idx !== ew || bad_state !== ee) begin
            n_fail++;
            $display("FAIL %s: vec=%b victim=%0d err=%0b expected vec=%b victim=%0d err=%0b",
                     req, age_vec, victim_idx, bad_state, ev, ew, ee);
        end
    endtask

    task automatic step(logic u, logic [1:0] i, logic w, logic [5:0] d);
        use_valid = u;
        use_idx   = i;
        wr_en     = w;
        wr_vec    = d;
        @(negedge clk);
        use_valid = 1'b0;
        wr_en     = 1'b0;
    endtask

    function automatic string use_req(logic [1:0] i);
        case (i)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        rst_n = 1'b0; use_valid = 1'b0; use_idx = '0; wr_en = 1'b0; wr_vec = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", 6'b000000, 2'd3, 1'b0);

        for (int k = 0; k < NV; k++) begin
            step(1'b1, VECS[k][10:9], 1'b0, '0);
            check(use_req(VECS[k][10:9]), VECS[k][8:3], VECS[k][2:1], VECS[k][0]);
        end

        // R9: idle cycles hold the vector
        step(1'b0, 2'd0, 1'b0, '0);
        step(1'b0, 2'd1, 1'b0, '0);
        check("R9 hold", 6'b111011, 2'd0, 1'b0);

        // R8 and R6: writes select each decode pattern
        step(1'b0, 2'd0, 1'b1, 6'b000010);
        check("R8/R6 way1", 6'b000010, 2'd1, 1'b0);
        step(1'b0, 2'd0, 1'b1, 6'b000001);
        check("R8/R6 way2", 6'b000001, 2'd2, 1'b0);
        step(1'b0, 2'd0, 1'b1, 6'b111111);
        check("R8/R6 way0 priority", 6'b111111, 2'd0, 1'b0);

        // R7: written vector that matches nothing
        step(1'b0, 2'd0, 1'b1, 6'b000110);
        check("R7 no match", 6'b000110, 2'd0, 1'b1);

        // R8: a write beats a simultaneous use
        step(1'b1, 2'd0, 1'b1, 6'b010101);
        check("R8 write wins", 6'b010101, 2'd0, 1'b1);

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid reset", 6'b000000, 2'd3, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule